// File: doc/BRIEF.md
# Modem Input Change Detector

This block is the status byte of a serial controller's modem-control inputs. It brings the asynchronous clear-to-send line into the clock domain through a synchronizer chain and reports its level. It also qualifies each change of that level with a minimum hold time. A qualified change sets a sticky change flag, which stays set until a CPU read of the status byte clears it. While the flag is set and interrupts are enabled, the block raises an interrupt request.

The same byte carries a sync indication whose source depends on the operating mode. It also carries constant bits that older software expects. The byte is always present on `rd_data`. Pulsing `rd_stb` for one cycle marks a CPU read. That read returns the byte as it stands in the strobe cycle and clears the change flag at the end of that cycle.

Top module: `mdm_chg_detect`

## Requirements
- R1: Bit 0 of `rd_data` shows the `cts_async` level after two synchronizing stages. A change driven just after a clock edge appears after the second following rising edge.
- R2: Bit 4 of `rd_data` is a sticky change flag. It sets once the synchronized CTS has held a level different from the last accepted level for MIN_STABLE consecutive cycles (default 4). A raw change driven just after an edge sets the flag on the sixth rising edge that follows.
- R3: A new level held for fewer than MIN_STABLE cycles sets no flag. A toggle back before the count completes restarts the count from zero.
- R4: In a cycle with `rd_stb` high, `rd_data` returns the current flag value. The flag is clear after that cycle's rising edge.
- R5: If a qualifying change completes in the same cycle as a read, the flag is still set after that edge.
- R6: `irq` is a registered copy of (flag AND `irq_en`). It follows `irq_en` one cycle later and is low in the cycle after a clearing read. `irq` is never high while the flag is clear.
- R7: Bit 7 of `rd_data` is the sync bit, chosen by `mode`. Codes 0 to 3 (asynchronous serial and three infrared rates) read 0. Codes 4 and 5 (8- and 16-bit modem) read the synchronized `ext_clk`. Code 6 (AC97 audio link) reads the synchronized `rts`. Code 7 reads 0.
- R8: Bits 3 and 2 of `rd_data` always read 1. Bits 6, 5 and 1 always read 0.
- R9: While `rst_n` is low, `rd_data` reads 0x0C and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_async | input | 1 | Raw clear-to-send line |
| ext_clk | input | 1 | Raw external clock line, the sync source in modem modes |
| rts | input | 1 | Raw request-to-send line, the sync source in audio link mode |
| mode | input | 3 | Operating mode code (see R7) |
| rd_stb | input | 1 | One-cycle CPU read strobe of the status byte |
| irq_en | input | 1 | Interrupt enable for the change flag |
| rd_data | output | 8 | Status byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded properties assume that `rd_stb`, `irq_en` and `mode` are synchronous to `clk` and settle before each rising edge. Only the three line inputs may change at any time. The bench changes every input on the falling edge, so that setup holds for all of them. Raw line changes are also timed from a falling edge, which fixes the edge count to each expected output. The stimulus holds `mode` steady across each sync-bit measurement.

// File: rtl/mdm_chg_pkg.sv
package mdm_chg_pkg;

   typedef enum logic [2:0] {
      MODE_ASYNC   = 3'd0,
      MODE_IR_LOW  = 3'd1,
      MODE_IR_MID  = 3'd2,
      MODE_IR_HIGH = 3'd3,
      MODE_MDM8    = 3'd4,
      MODE_MDM16   = 3'd5,
      MODE_AUDIO   = 3'd6,
      MODE_SPARE   = 3'd7
   } op_mode_t;

   localparam int STAT_W      = 8;
   localparam int BIT_LEVEL   = 0;
   localparam int BIT_CHANGE  = 4;
   localparam int BIT_SYNC    = 7;
   localparam logic [STAT_W-1:0] FIXED_ONES = 8'h0C;
   localparam logic [STAT_W-1:0] FIXED_MASK = 8'h6E;

   // line indices inside the synchronizer bank
   localparam int LN_CTS  = 0;
   localparam int LN_EXT  = 1;
   localparam int LN_RTS  = 2;
   localparam int N_LINES = 3;

endpackage

// File: rtl/mdm_sync_bank.sv
module mdm_sync_bank #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mdm_sync_bank: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("mdm_sync_bank: WIDTH must be at least 1");
      end
   endgenerate

   for (genvar b = 0; b < WIDTH; b++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/mdm_stable_filter.sv
module mdm_stable_filter #(
   parameter int MIN_STABLE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic evt_o,
   output logic acc_o
);

   localparam int CNT_W = (MIN_STABLE > 1) ? $clog2(MIN_STABLE) : 1;

   generate
      if (MIN_STABLE < 1) begin : g_bad_min
         $error("mdm_stable_filter: MIN_STABLE must be at least 1");
      end
   endgenerate

   logic acc_q;
   logic differ;

   assign differ = (lvl_i != acc_q);

   generate
      if (MIN_STABLE == 1) begin : g_direct
         assign evt_o = differ;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_STABLE - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (!differ || cnt_q == LAST) cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
         end

         assign evt_o = differ && (cnt_q == LAST);

         // R3
         cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);

         // R3
         cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !differ |=> cnt_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= 1'b0;
      else if (evt_o) acc_q <= lvl_i;
   end

   assign acc_o = acc_q;

   // R2
   acc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q != $past(acc_q)) |-> (acc_q == $past(lvl_i)));

endmodule

// File: rtl/mdm_delta_flag.sv
module mdm_delta_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic rd_stb_i,
   input  logic irq_en_i,
   output logic flag_o,
   output logic irq_o
);

   logic flag_q;
   logic flag_d;
   logic irq_q;

   // a completing change wins over a clearing read
   assign flag_d = evt_i | (flag_q & ~rd_stb_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         flag_q <= flag_d;
         irq_q  <= flag_d & irq_en_i;
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = irq_q;

   // R2
   evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_q);

   // R2
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !rd_stb_i) |=> flag_q);

   // R4
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && !evt_i) |=> !flag_q);

   // R5
   read_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && evt_i) |=> flag_q);

   // R6
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> flag_q);

   // R6
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && !evt_i) |=> !irq_q);

   // R6
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i |=> !irq_q);

endmodule

// File: rtl/mdm_chg_detect.sv
module mdm_chg_detect
   import mdm_chg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_STABLE  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cts_async,
   input  logic       ext_clk,
   input  logic       rts,
   input  logic [2:0] mode,
   input  logic       rd_stb,
   input  logic       irq_en,
   output logic [7:0] rd_data,
   output logic       irq
);

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] sync_lines;
   logic               cts_s;
   logic               chg_evt;
   logic               acc_lvl;
   logic               chg_flag;
   logic               sync_bit;
   op_mode_t           mode_e;

   assign raw_lines[LN_CTS] = cts_async;
   assign raw_lines[LN_EXT] = ext_clk;
   assign raw_lines[LN_RTS] = rts;

   mdm_sync_bank #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_lines),
      .q_sync  (sync_lines)
   );

   assign cts_s = sync_lines[LN_CTS];

   mdm_stable_filter #(
      .MIN_STABLE (MIN_STABLE)
   ) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (cts_s),
      .evt_o (chg_evt),
      .acc_o (acc_lvl)
   );

   mdm_delta_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (chg_evt),
      .rd_stb_i (rd_stb),
      .irq_en_i (irq_en),
      .flag_o   (chg_flag),
      .irq_o    (irq)
   );

   assign mode_e = op_mode_t'(mode);

   always_comb begin
      unique case (mode_e)
         MODE_MDM8, MODE_MDM16: sync_bit = sync_lines[LN_EXT];
         MODE_AUDIO:            sync_bit = sync_lines[LN_RTS];
         default:               sync_bit = 1'b0;
      endcase
   end

   always_comb begin
      rd_data             = FIXED_ONES;
      rd_data[BIT_LEVEL]  = cts_s;
      rd_data[BIT_CHANGE] = chg_flag;
      rd_data[BIT_SYNC]   = sync_bit;
   end

   // R8
   fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & FIXED_MASK) == FIXED_ONES);

   // R7
   sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e != MODE_MDM8 && mode_e != MODE_MDM16 && mode_e != MODE_AUDIO)
      |-> !rd_data[BIT_SYNC]);

   // R2
   flag_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_lvl != $past(acc_lvl)) |-> rd_data[BIT_CHANGE]);

endmodule

// File: tb/mdm_chg_detect_tb.sv
`timescale 1ns/1ps
module mdm_chg_detect_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cts_async, ext_clk, rts, rd_stb, irq_en;
   logic [2:0] mode;
   logic [7:0] rd_data;
   logic       irq;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   mdm_chg_detect u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cts_async (cts_async),
      .ext_clk   (ext_clk),
      .rts       (rts),
      .mode      (mode),
      .rd_stb    (rd_stb),
      .irq_en    (irq_en),
      .rd_data   (rd_data),
      .irq       (irq)
   );

   // {mode, ext_clk, rts, expected sync bit}
   localparam logic [5:0] SYNC_TBL [8] = '{
      {3'd0, 1'b1, 1'b1, 1'b0},
      {3'd3, 1'b1, 1'b1, 1'b0},
      {3'd4, 1'b1, 1'b0, 1'b1},
      {3'd4, 1'b0, 1'b1, 1'b0},
      {3'd5, 1'b1, 1'b0, 1'b1},
      {3'd6, 1'b0, 1'b1, 1'b1},
      {3'd6, 1'b1, 1'b0, 1'b0},
      {3'd7, 1'b1, 1'b1, 1'b0}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_byte(output logic [7:0] val);
      rd_stb = 1'b1;
      #1 val = rd_data;
      tick(1);
      rd_stb = 1'b0;
   endtask

   initial begin
      #1000000;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      logic [7:0] v;
      rst_n = 1'b0; cts_async = 1'b0; ext_clk = 1'b0; rts = 1'b0;
      rd_stb = 1'b0; irq_en = 1'b1; mode = 3'd0;
      tick(3);
      // R9 reset value
      check("R9", rd_data, 8'h0C);
      check("R9", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;
      tick(2);

      // R7, R8: sync source table
      for (int i = 0; i < 8; i++) begin
         mode    = SYNC_TBL[i][5:3];
         ext_clk = SYNC_TBL[i][2];
         rts     = SYNC_TBL[i][1];
         tick(3);
         check("R7", {7'b0, rd_data[7]}, {7'b0, SYNC_TBL[i][0]});
         check("R8", rd_data & 8'h6E, 8'h0C);
      end
      mode = 3'd0; ext_clk = 1'b0; rts = 1'b0;
      tick(3);

      // R1 level latency, R2 flag timing
      cts_async = 1'b1;
      tick(1);
      check("R1", {7'b0, rd_data[0]}, 8'h00);
      tick(1);
      check("R1", {7'b0, rd_data[0]}, 8'h01);
      tick(3);
      check("R2", {7'b0, rd_data[4]}, 8'h00);
      tick(1);
      check("R2", {7'b0, rd_data[4]}, 8'h01);
      check("R6", {7'b0, irq}, 8'h01);

      // R4 read returns flag then clears
      read_byte(v);
      check("R4", {7'b0, v[4]}, 8'h01);
      check("R4", {7'b0, rd_data[4]}, 8'h00);
      check("R6", {7'b0, irq}, 8'h00);

      // R3 short glitch of MIN_STABLE-1 cycles
      cts_async = 1'b0; tick(3); cts_async = 1'b1;
      tick(10);
      check("R3", {7'b0, rd_data[4]}, 8'h00);

      // R3 count restart: low 3, high 1, low 3
      cts_async = 1'b0; tick(3); cts_async = 1'b1; tick(1);
      cts_async = 1'b0; tick(3); cts_async = 1'b1;
      tick(10);
      check("R3", {7'b0, rd_data[4]}, 8'h00);

      // R2 exactly MIN_STABLE cycles qualifies
      cts_async = 1'b0; tick(4); cts_async = 1'b1;
      tick(12);
      check("R2", {7'b0, rd_data[4]}, 8'h01);
      read_byte(v);
      tick(8);
      check("R4", {7'b0, rd_data[4]}, 8'h00);

      // R5 change completing during a read
      cts_async = 1'b0; tick(12);
      check("R2", {7'b0, rd_data[4]}, 8'h01);
      cts_async = 1'b1;
      tick(5);
      read_byte(v);
      check("R5", {7'b0, v[4]}, 8'h01);
      check("R5", {7'b0, rd_data[4]}, 8'h01);

      // R6 enable gating
      irq_en = 1'b0; tick(1);
      check("R6", {7'b0, irq}, 8'h00);
      irq_en = 1'b1; tick(1);
      check("R6", {7'b0, irq}, 8'h01);
      read_byte(v);
      check("R6", {7'b0, irq}, 8'h00);

      // R9 reset mid-run
      rst_n = 1'b0;
      #1;
      check("R9", rd_data, 8'h0C);
      check("R9", {7'b0, irq}, 8'h00);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule